// File: doc/BRIEF.md
# Serial Register Port with Deferred Commit

This block is the slave side of a four-wire serial control port that feeds a file of byte-wide configuration registers. The port has an active-low select, a serial clock, and separate input and output data lines. Every transfer opens with a 16-bit instruction word that gives the direction, the transfer length and a 13-bit start address. The data bytes follow it. All serial bits travel most significant bit first.

Writes land in a shadow copy of each register. They reach the live copy only when a dedicated update location is written with its commit bit set, and then every register changes in the same clock. The live copy drives a parallel bus that the surrounding logic uses directly. Reads return live values. The port pins are brought into the block's own clock domain through a short synchronizer, and the serial clock edges are detected there. The serial clock therefore has to run well below the block clock.

Top module: `spiRegPort`

## Requirements
- R1: After reset, register 0x00 holds 0x10 on the live bus. Every other register holds 0x00, and the output data line is low.
- R2: The instruction word is 16 bits, sent most significant bit first. Bit 15 is 1 for a read and 0 for a write. Bits 14:13 are the length code. Bits 12:0 are the start address. A single-byte write is 24 serial clocks: the instruction followed by 8 data bits.
- R3: A write changes only the shadow copy. The live bus does not change until a commit.
- R4: A data byte with bit 0 set, written to the update address 0x5A, copies every shadow register into its live register in a single clock. The same write with bit 0 clear changes nothing.
- R5: The commit bit clears itself. The update address always reads back as 0x00 and never holds a value on the live bus.
- R6: Length codes 00, 01 and 10 move 1, 2 and 3 data bytes. Any further bits before select rises are ignored.
- R7: Length code 11 keeps moving bytes until select rises.
- R8: The address decrements by one after every data byte of a transfer.
- R9: A read returns the live value, not the shadow value. It is driven most significant bit first on the output line, and each bit changes only after a falling serial clock edge.
- R10: If select rises before a byte is complete, that partial byte, whether data or instruction, is dropped. The next transfer starts with a fresh instruction.
- R11: Writes to addresses at or above the register count are dropped. Reads from those addresses return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; the serial pins are sampled with it |
| rst | input | 1 | Synchronous active-high reset |
| csN | input | 1 | Active-low port select |
| sclk | input | 1 | Serial clock; input data is taken on the rising edge |
| sdi | input | 1 | Serial data into the port |
| sdo | output | 1 | Serial read data out of the port |
| activeBus | output | REG_COUNT*8 | Live register values; register n occupies bits 8n+7:8n |

## Verification
The bench builds the port with 96 registers, so the update location 0x5A sits inside the file and addresses from 0x60 upward exercise the out-of-range path. It uses a two-stage synchronizer and a serial half-period of six block clocks. These settings let it walk a decrementing stream across many registers and write past the end of the file. On every clock it checks that a commit changes the whole bus in one step. It also sends partial instructions and partial data bytes and checks that they leave no trace.

// File: rtl/spiRegPkg.sv
package spiRegPkg;

  localparam int ADDR_W = 13;

  typedef enum logic [1:0] {
    PH_INSTR = 2'd0,
    PH_DATA  = 2'd1,
    PH_DONE  = 2'd2
  } spiPhase_t;

  // Control-to-datapath strobes, valid for one block clock each
  typedef struct packed {
    logic              shiftIn;  // take one bit from the input line
    logic              wrEn;     // store the received byte into the shadow copy
    logic              commit;   // copy all shadow registers into the live copy
    logic              loadTx;   // load the read byte at addr into the output shifter
    logic              shiftTx;  // present the next output bit
    logic              clearTx;  // port deselected: idle the output side
    logic [ADDR_W-1:0] addr;     // register address for wrEn / loadTx
  } spiStrobe_t;

endpackage

// File: rtl/spiPinSync.sv
module spiPinSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic csNIn,
  input  logic sclkIn,
  input  logic sdiIn,
  output logic csHigh,
  output logic riseEv,
  output logic fallEv,
  output logic sdiS
);

  logic [STAGES-1:0] csPipe;
  logic [STAGES-1:0] sclkPipe;
  logic [STAGES-1:0] sdiPipe;
  logic              sclkPrev;
  logic              sclkS;

  always_ff @(posedge clk) begin
    if (rst) begin
      csPipe   <= '1;
      sclkPipe <= '1;
      sdiPipe  <= '0;
      sclkPrev <= 1'b1;
    end else begin
      csPipe   <= {csPipe[STAGES-2:0], csNIn};
      sclkPipe <= {sclkPipe[STAGES-2:0], sclkIn};
      sdiPipe  <= {sdiPipe[STAGES-2:0], sdiIn};
      sclkPrev <= sclkPipe[STAGES-1];
    end
  end

  assign csHigh = csPipe[STAGES-1];
  assign sclkS  = sclkPipe[STAGES-1];
  assign sdiS   = sdiPipe[STAGES-1];
  assign riseEv = !csHigh && sclkS && !sclkPrev;
  assign fallEv = !csHigh && !sclkS && sclkPrev;

endmodule

// File: rtl/spiRegCtrl.sv
module spiRegCtrl
  import spiRegPkg::*;
#(
  parameter logic [ADDR_W-1:0] UPD_ADDR = 13'h05A
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       csHigh,
  input  logic       riseEv,
  input  logic       fallEv,
  input  logic [7:0] rxByte,
  output spiStrobe_t strb
);

  spiPhase_t         phase;
  logic [2:0]        bitCnt;
  logic              haveHi;
  logic [7:0]        instrHi;
  logic              isRead;
  logic              streamMode;
  logic [1:0]        bytesLeft;
  logic [ADDR_W-1:0] curAddr;

  logic              byteDone;
  logic              instrDone;
  logic              dataByte;
  logic              moreBytes;
  logic [ADDR_W-1:0] stepAddr;
  logic [ADDR_W-1:0] newAddr;

  assign byteDone  = riseEv && (bitCnt == 3'd7);
  assign instrDone = byteDone && (phase == PH_INSTR) && haveHi;
  assign dataByte  = byteDone && (phase == PH_DATA);
  assign moreBytes = streamMode || (bytesLeft != 2'd0);
  assign stepAddr  = curAddr - ADDR_W'(1);
  assign newAddr   = {instrHi[4:0], rxByte};

  always_ff @(posedge clk) begin
    if (rst || csHigh) begin
      phase     <= PH_INSTR;
      bitCnt    <= 3'd0;
      haveHi    <= 1'b0;
      instrHi   <= 8'h00;
      isRead    <= 1'b0;
      streamMode<= 1'b0;
      bytesLeft <= 2'd0;
      if (rst) curAddr <= '0;
    end else if (riseEv) begin
      bitCnt <= bitCnt + 3'd1;
      if (byteDone) begin
        unique case (phase)
          PH_INSTR: begin
            if (!haveHi) begin
              instrHi <= rxByte;
              haveHi  <= 1'b1;
            end else begin
              isRead     <= instrHi[7];
              streamMode <= (instrHi[6:5] == 2'b11);
              bytesLeft  <= instrHi[6:5];
              curAddr    <= newAddr;
              phase      <= PH_DATA;
            end
          end
          PH_DATA: begin
            curAddr <= stepAddr;
            if (!streamMode) begin
              if (bytesLeft == 2'd0) phase <= PH_DONE;
              else bytesLeft <= bytesLeft - 2'd1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    strb         = '0;
    strb.shiftIn = riseEv;
    strb.shiftTx = fallEv;
    strb.clearTx = csHigh;
    strb.wrEn    = dataByte && !isRead;
    strb.commit  = dataByte && !isRead && (curAddr == UPD_ADDR) && rxByte[0];
    strb.loadTx  = (instrDone && instrHi[7]) || (dataByte && isRead && moreBytes);
    if (instrDone)      strb.addr = newAddr;
    else if (strb.wrEn) strb.addr = curAddr;
    else                strb.addr = stepAddr;
  end

  // R6
  done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_DONE) |-> !(strb.wrEn || strb.loadTx));

  // R10
  cs_restart_chk: assert property (@(posedge clk) disable iff (rst)
    csHigh |=> (phase == PH_INSTR && bitCnt == 3'd0 && !haveHi));

  // R8
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (byteDone && phase == PH_DATA) |=> (curAddr == $past(curAddr) - ADDR_W'(1)));

  // R5
  commit_src_chk: assert property (@(posedge clk) disable iff (rst)
    strb.commit |-> (strb.wrEn && strb.addr == UPD_ADDR));

endmodule

// File: rtl/spiRegData.sv
module spiRegData
  import spiRegPkg::*;
#(
  parameter int                REG_COUNT = 96,
  parameter logic [ADDR_W-1:0] UPD_ADDR  = 13'h05A,
  parameter logic [ADDR_W-1:0] CFG_ADDR  = 13'h000,
  parameter logic [7:0]        CFG_RESET = 8'h10
) (
  input  logic                   clk,
  input  logic                   rst,
  input  spiStrobe_t             strb,
  input  logic                   sdiS,
  output logic [7:0]             rxByte,
  output logic                   sdo,
  output logic [REG_COUNT*8-1:0] activeBus
);

  localparam int                IDX_W       = $clog2(REG_COUNT);
  localparam logic [ADDR_W-1:0] REG_COUNT_A = ADDR_W'(REG_COUNT);

  logic [7:0]             shadowQ [REG_COUNT];
  logic [7:0]             activeQ [REG_COUNT];
  logic [REG_COUNT*8-1:0] shadowFlat;
  logic [6:0]             rxShift;
  logic [7:0]             txQ;
  logic                   sdoQ;
  logic                   inRange;
  logic                   wrHit;
  logic [IDX_W-1:0]       regIdx;
  logic [7:0]             rdByte;

  assign rxByte  = {rxShift, sdiS};
  assign inRange = (strb.addr < REG_COUNT_A) && (strb.addr != UPD_ADDR);
  assign regIdx  = strb.addr[IDX_W-1:0];
  assign wrHit   = strb.wrEn && inRange;
  assign rdByte  = inRange ? activeQ[regIdx] : 8'h00;

  always_ff @(posedge clk) begin
    if (rst) rxShift <= '0;
    else if (strb.shiftIn) rxShift <= {rxShift[5:0], sdiS};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < REG_COUNT; i++) begin
        shadowQ[i] <= (ADDR_W'(i) == CFG_ADDR) ? CFG_RESET : 8'h00;
        activeQ[i] <= (ADDR_W'(i) == CFG_ADDR) ? CFG_RESET : 8'h00;
      end
    end else begin
      if (wrHit) shadowQ[regIdx] <= rxByte;
      if (strb.commit) begin
        for (int i = 0; i < REG_COUNT; i++) activeQ[i] <= shadowQ[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || strb.clearTx) begin
      txQ  <= 8'h00;
      sdoQ <= 1'b0;
    end else if (strb.loadTx) begin
      txQ <= rdByte;
    end else if (strb.shiftTx) begin
      sdoQ <= txQ[7];
      txQ  <= {txQ[6:0], 1'b0};
    end
  end

  for (genvar g = 0; g < REG_COUNT; g++) begin : g_flat
    assign activeBus[g*8 +: 8]  = activeQ[g];
    assign shadowFlat[g*8 +: 8] = shadowQ[g];
  end

  assign sdo = sdoQ;

  // R3
  live_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strb.commit |=> $stable(activeBus));

  // R4
  commit_copy_chk: assert property (@(posedge clk) disable iff (rst)
    strb.commit |=> (activeBus == $past(shadowFlat)));

  // R9
  sdo_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!strb.shiftTx && !strb.clearTx) |=> $stable(sdo));

  // R11
  rd_outside_chk: assert property (@(posedge clk) disable iff (rst)
    (strb.loadTx && strb.addr >= REG_COUNT_A) |=> (txQ == 8'h00));

endmodule

// File: rtl/spiRegPort.sv
module spiRegPort
  import spiRegPkg::*;
#(
  parameter int                REG_COUNT   = 96,
  parameter logic [ADDR_W-1:0] UPD_ADDR    = 13'h05A,
  parameter logic [ADDR_W-1:0] CFG_ADDR    = 13'h000,
  parameter logic [7:0]        CFG_RESET   = 8'h10,
  parameter int                SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   csN,
  input  logic                   sclk,
  input  logic                   sdi,
  output logic                   sdo,
  output logic [REG_COUNT*8-1:0] activeBus
);

  logic       csHigh;
  logic       riseEv;
  logic       fallEv;
  logic       sdiS;
  logic [7:0] rxByte;
  spiStrobe_t strb;

  spiPinSync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .csNIn(csN), .sclkIn(sclk), .sdiIn(sdi),
    .csHigh(csHigh), .riseEv(riseEv), .fallEv(fallEv), .sdiS(sdiS)
  );

  spiRegCtrl #(.UPD_ADDR(UPD_ADDR)) ctrl_i (
    .clk(clk), .rst(rst), .csHigh(csHigh), .riseEv(riseEv),
    .fallEv(fallEv), .rxByte(rxByte), .strb(strb)
  );

  spiRegData #(
    .REG_COUNT(REG_COUNT), .UPD_ADDR(UPD_ADDR),
    .CFG_ADDR(CFG_ADDR), .CFG_RESET(CFG_RESET)
  ) data_i (
    .clk(clk), .rst(rst), .strb(strb), .sdiS(sdiS),
    .rxByte(rxByte), .sdo(sdo), .activeBus(activeBus)
  );

endmodule

// File: tb/spiRegPort_tb.sv
`timescale 1ns/1ps
module spiRegPort_tb_top;

  localparam int NREG = 96;
  localparam int HALF = 6;
  localparam logic [12:0] UPD = 13'h05A;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic csN = 1'b1;
  logic sclk = 1'b1;
  logic sdi = 1'b0;
  logic sdo;
  logic [NREG*8-1:0] activeBus;

  int errors = 0;
  int checks = 0;
  bit cmpEn = 1'b0;
  bit finished = 1'b0;
  int changeCnt = 0;
  logic [NREG*8-1:0] prevBus;

  logic [7:0] modelShadow [NREG];
  logic [7:0] modelActive [NREG];
  logic [7:0] wbuf [16];

  always #10 clk = ~clk;

  spiRegPort #(.REG_COUNT(NREG)) dut_i (
    .clk(clk), .rst(rst), .csN(csN), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .activeBus(activeBus)
  );

  function automatic logic [NREG*8-1:0] modelBus();
    logic [NREG*8-1:0] v;
    for (int i = 0; i < NREG; i++) v[i*8 +: 8] = modelActive[i];
    return v;
  endfunction

  function automatic logic [7:0] expRead(logic [12:0] a);
    if (a < 13'(NREG) && a != UPD) return modelActive[a[6:0]];
    return 8'h00;
  endfunction

  function automatic void modelWrite(logic [12:0] a, logic [7:0] d);
    if (a == UPD) begin
      if (d[0]) for (int i = 0; i < NREG; i++) modelActive[i] = modelShadow[i];
    end else if (a < 13'(NREG)) begin
      modelShadow[a[6:0]] = d;
    end
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Every-clock comparison of the live bus against the model
  always @(negedge clk) begin
    if (!rst) begin
      if (activeBus !== prevBus) changeCnt++;
      if (cmpEn) begin
        checks++;
        if (activeBus !== modelBus()) begin
          errors++;
          $display("FAIL R3 live bus: actual=%0h expected=%0h", activeBus, modelBus());
        end
      end
    end
    prevBus = activeBus;
  end

  task automatic bitOut(input logic v, output logic s);
    @(negedge clk);
    sclk = 1'b0;
    sdi  = v;
    repeat (HALF) @(negedge clk);
    s    = sdo;
    sclk = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic xfer(string tag, bit rd, logic [1:0] len, logic [12:0] addr,
                      int nSend, int partial);
    logic [15:0] instr;
    logic [7:0]  rb;
    logic        s;
    int          limit;
    instr = {rd, len, addr};
    limit = (len == 2'b11) ? nSend : int'(len) + 1;
    cmpEn = 1'b0;
    changeCnt = 0;
    @(negedge clk);
    csN = 1'b0;
    repeat (4) @(negedge clk);
    for (int b = 15; b >= 0; b--) bitOut(instr[b], s);
    for (int k = 0; k < nSend; k++) begin
      for (int b = 7; b >= 0; b--) begin
        bitOut(rd ? 1'b0 : wbuf[k][b], s);
        rb[b] = s;
      end
      if (rd && k < limit) check({tag, " read byte"}, 64'(rb), 64'(expRead(addr - 13'(k))));
    end
    for (int p = 0; p < partial; p++) bitOut(1'b1, s);
    repeat (HALF) @(negedge clk);
    csN  = 1'b1;
    sclk = 1'b1;
    repeat (12) @(negedge clk);
    if (!rd) begin
      for (int k = 0; k < nSend && k < limit; k++) modelWrite(addr - 13'(k), wbuf[k]);
    end
    cmpEn = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic rawBits(int n);
    logic s;
    cmpEn = 1'b0;
    changeCnt = 0;
    @(negedge clk);
    csN = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < n; i++) bitOut(1'b1, s);
    repeat (HALF) @(negedge clk);
    csN = 1'b1;
    repeat (12) @(negedge clk);
    cmpEn = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic commitAll(string tag, int expChanges);
    wbuf[0] = 8'h01;
    xfer(tag, 1'b0, 2'b00, UPD, 1, 0);
    check({tag, " commit steps"}, 64'(changeCnt), 64'(expChanges));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NREG; i++) begin
      modelShadow[i] = (i == 0) ? 8'h10 : 8'h00;
      modelActive[i] = modelShadow[i];
    end
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 reg0", 64'(activeBus[7:0]), 64'h10);
    check("R1 bus", 64'(activeBus == modelBus()), 64'd1);
    check("R1 sdo", 64'(sdo), 64'd0);
    cmpEn = 1'b1;

    // R2 R3 single-byte write stays in shadow
    wbuf[0] = 8'h80;
    xfer("R2", 1'b0, 2'b00, 13'h03D, 1, 0);
    check("R3 no live change", 64'(changeCnt), 64'd0);
    // R9 read returns live (old) value, not shadow
    xfer("R9", 1'b1, 2'b00, 13'h03D, 1, 0);

    // R4 commit in one clock; R5 update reads 0
    commitAll("R4", 1);
    check("R4 reg3d", 64'(activeBus[8'h3D*8 +: 8]), 64'h80);
    xfer("R5", 1'b1, 2'b00, UPD, 1, 0);
    check("R5 upd bus", 64'(activeBus[UPD*8 +: 8]), 64'h00);
    xfer("R9", 1'b1, 2'b00, 13'h03D, 1, 0);
    xfer("R1", 1'b1, 2'b00, 13'h000, 1, 0);

    // R4 update with bit 0 clear does nothing
    wbuf[0] = 8'h55;
    xfer("R3", 1'b0, 2'b00, 13'h020, 1, 0);
    wbuf[0] = 8'hFE;
    xfer("R4", 1'b0, 2'b00, UPD, 1, 0);
    check("R4 no commit", 64'(changeCnt), 64'd0);

    // R6 R8 three-byte write with an extra byte sent
    wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3; wbuf[3] = 8'hD4;
    xfer("R6", 1'b0, 2'b10, 13'h00C, 4, 0);
    // R6 two-byte write with an extra byte
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    xfer("R6", 1'b0, 2'b01, 13'h040, 3, 0);
    commitAll("R8", 1);
    check("R6 reg09 untouched", 64'(activeBus[8'h09*8 +: 8]), 64'h00);
    check("R8 reg0a", 64'(activeBus[8'h0A*8 +: 8]), 64'hC3);

    // R7 streaming write of six bytes
    for (int k = 0; k < 6; k++) wbuf[k] = 8'(8'h60 + k);
    xfer("R7", 1'b0, 2'b11, 13'h015, 6, 0);
    commitAll("R7", 1);
    check("R7 reg10", 64'(activeBus[8'h10*8 +: 8]), 64'h65);

    // R10 partial data byte dropped, then partial instruction dropped
    wbuf[0] = 8'h77;
    xfer("R10", 1'b0, 2'b00, 13'h030, 0, 5);
    rawBits(10);
    wbuf[0] = 8'h99;
    xfer("R10", 1'b0, 2'b00, 13'h031, 1, 0);
    commitAll("R10", 1);
    check("R10 reg30", 64'(activeBus[8'h30*8 +: 8]), 64'h00);
    check("R10 reg31", 64'(activeBus[8'h31*8 +: 8]), 64'h99);

    // R11 out-of-range write and read
    wbuf[0] = 8'hEE;
    xfer("R11", 1'b0, 2'b00, 13'h100, 1, 0);
    commitAll("R11", 0);
    xfer("R11", 1'b1, 2'b00, 13'h100, 1, 0);

    // R7 R8 R9 streaming read across registers
    xfer("R7", 1'b1, 2'b11, 13'h015, 6, 0);
    xfer("R8", 1'b1, 2'b10, 13'h00C, 3, 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule